// File: doc/BRIEF.md
# Parallel-In Serial-Out Word Buffer

This block buffers up to 1024 sixteen-bit words. A producer presents a word on a parallel bus and pulses an active-low write strobe; a consumer pulls the buffered data one bit at a time on a single serial line by toggling a shift clock. Both the strobe and the shift clock are ordinary inputs sampled on the one system clock, so their edges are detected synchronously and act as enables.

The word at the head of the buffer sits in an output shift register. Each detected rising edge of the shift clock retires the bit on the serial line and exposes the next one. After sixteen bits the next stored word is pulled into the shift register automatically. A bit-order input picks least-significant-first or most-significant-first, and the shift register takes that choice when it loads a word. Four registered status flags describe the stored word count, which includes the word in the shift register: empty, full, at least half full, and a combined near-empty/near-full indication.

Top module: `pso_fifo`

## Requirements
- R1: While `rst` is high and on the first edge after it, `empty` is 1 and `full`, `half_full`, `near_edge` and `ser_out` are 0.
- R2: A word is stored when `wstb_n` is seen low and then high on successive clock samples; `din` is captured on the sample where `wstb_n` is first seen high again.
- R3: If the buffer holds 1024 words when `wstb_n` is first seen low, the following rise stores nothing and the count does not change.
- R4: Each rising edge of `shclk` that finds a word in the shift register moves the next bit to `ser_out`; after 16 bits the next stored word is loaded within two clocks. `shclk` edges must be at least four clocks apart. `ser_out` is 0 while no word is loaded.
- R5: `msb_first` = 0 sends bit 0 of a word first and bit 15 last; `msb_first` = 1 sends bit 15 first and bit 0 last. The level is taken when a word enters the shift register.
- R6: `empty` is 1 exactly when the count is 0; `full` is 1 exactly when the count is 1024.
- R7: `half_full` is 1 exactly when the count is 512 or more.
- R8: `near_edge` is 1 exactly when the count is 8 or less, or 1016 or more.
- R9: Every flag reflects the count one clock after the count changes; the count includes the word in the shift register, so `near_edge` rises on the first edge after reset ends.
- R10: A store and the retirement of the last bit of a word in the same clock leave the count unchanged.
- R11: `shclk` edges while `empty` is 1 are ignored: the first word written afterwards is sent complete from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wstb_n | input | 1 | Active-low write strobe, sampled on `clk` |
| din | input | 16 | Parallel write data |
| shclk | input | 1 | Serial shift clock, sampled on `clk` |
| msb_first | input | 1 | Bit order: 0 least significant first, 1 most significant first |
| ser_out | output | 1 | Serial data output |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count is 1024 |
| half_full | output | 1 | Count is 512 or more |
| near_edge | output | 1 | Count is 8 or less, or 1016 or more |

## Verification
The two functions that can fall in the same clock are a word store and the retirement of the last bit of the word in the shift register. The bench provokes this by raising the write strobe and the shift clock on the same clock sample with the count parked at 9 and at 8, where a lost increment or lost decrement would move `near_edge` across its lower threshold. The flags after the collision are judged against a bench count that adds one and removes one, and the serial stream that follows must still carry both words intact.

// File: rtl/pso_pkg.sv
package pso_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
    logic near;
  } pso_flags_t;
endpackage

// File: rtl/pso_sample.sv
module pso_sample #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= INIT;
    else     q <= d;
  end
endmodule

// File: rtl/pso_ram.sv
module pso_ram #(
  parameter int W  = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << AW;
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pso_shifter.sv
module pso_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         load_msb,
  input  logic         shift,
  output logic         valid,
  output logic         last,
  output logic         sout
);
  localparam int IW = $clog2(W);
  logic [W-1:0]  sreg;
  logic [IW-1:0] idx;
  logic          msb;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      idx   <= '0;
      msb   <= 1'b0;
      valid <= 1'b0;
    end else if (load) begin
      sreg  <= load_word;
      idx   <= '0;
      msb   <= load_msb;
      valid <= 1'b1;
    end else if (shift) begin
      sreg <= msb ? (sreg << 1) : (sreg >> 1);
      if (idx == IW'(W - 1)) valid <= 1'b0;
      idx <= idx + IW'(1);
    end
  end

  assign last = (idx == IW'(W - 1));
  assign sout = valid & (msb ? sreg[W-1] : sreg[0]);
endmodule

// File: rtl/pso_flags.sv
module pso_flags
  import pso_pkg::*;
#(
  parameter int CW       = 11,
  parameter int DEPTH    = 1024,
  parameter int AE_LEVEL = 8,
  parameter int AF_LEVEL = 1016
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [CW-1:0] cnt,
  output pso_flags_t flags
);
  localparam int HALF_LEVEL = DEPTH / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags.empty <= 1'b1;
      flags.full  <= 1'b0;
      flags.half  <= 1'b0;
      flags.near  <= 1'b0;
    end else begin
      flags.empty <= (cnt == '0);
      flags.full  <= (cnt == CW'(DEPTH));
      flags.half  <= (cnt >= CW'(HALF_LEVEL));
      flags.near  <= (cnt <= CW'(AE_LEVEL)) || (cnt >= CW'(AF_LEVEL));
    end
  end
endmodule

// File: rtl/pso_fifo.sv
module pso_fifo
  import pso_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 1024,
  parameter int AE_LEVEL = 8,
  parameter int AF_LEVEL = DEPTH - 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wstb_n,
  input  logic [DATA_W-1:0] din,
  input  logic              shclk,
  input  logic              msb_first,
  output logic              ser_out,
  output logic              empty,
  output logic              full,
  output logic              half_full,
  output logic              near_edge
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic wstb_q, shclk_q;
  logic wr_fall, wr_rise, sh_rise;
  logic armed, wr_fire;
  logic [AW:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic pend, fetch_go;
  logic [DATA_W-1:0] rdata;
  logic sh_valid, sh_last, shift_go, word_done;
  pso_flags_t flags;

  pso_sample #(.INIT(1'b1)) u_wsmp (.clk(clk), .rst(rst), .d(wstb_n), .q(wstb_q));
  pso_sample #(.INIT(1'b0)) u_ssmp (.clk(clk), .rst(rst), .d(shclk),  .q(shclk_q));

  assign wr_fall = wstb_q & ~wstb_n;
  assign wr_rise = ~wstb_q & wstb_n;
  assign sh_rise = ~shclk_q & shclk;

  // write admission decided on the falling strobe from the live count
  always_ff @(posedge clk) begin
    if (rst)          armed <= 1'b0;
    else if (wr_fall) armed <= (cnt != CW'(DEPTH));
    else if (wr_rise) armed <= 1'b0;
  end
  assign wr_fire = wr_rise & armed;

  assign fetch_go  = ~sh_valid & ~pend & (wptr != rptr);
  assign shift_go  = sh_rise & ~flags.empty & sh_valid;
  assign word_done = shift_go & sh_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      pend <= 1'b0;
      cnt  <= '0;
    end else begin
      if (wr_fire)  wptr <= wptr + (AW+1)'(1);
      if (fetch_go) rptr <= rptr + (AW+1)'(1);
      pend <= fetch_go;
      case ({wr_fire, word_done})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  pso_ram #(.W(DATA_W), .AW(AW)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(wptr[AW-1:0]), .wdata(din),
    .raddr(rptr[AW-1:0]), .rdata(rdata)
  );

  pso_shifter #(.W(DATA_W)) u_shf (
    .clk(clk), .rst(rst), .load(pend), .load_word(rdata), .load_msb(msb_first),
    .shift(shift_go), .valid(sh_valid), .last(sh_last), .sout(ser_out)
  );

  pso_flags #(.CW(CW), .DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL)) u_flg (
    .clk(clk), .rst(rst), .cnt(cnt), .flags(flags)
  );

  assign empty     = flags.empty;
  assign full      = flags.full;
  assign half_full = flags.half;
  assign near_edge = flags.near;
endmodule

// File: rtl/pso_fifo_chk.sv
module pso_fifo_chk #(
  parameter int DEPTH    = 1024,
  parameter int AE_LEVEL = 8,
  parameter int AF_LEVEL = 1016,
  parameter int CW       = 11
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic          wr_fire,
  input logic          empty,
  input logic          full,
  input logic          half_full,
  input logic          near_edge
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(DEPTH)) |-> !wr_fire);
  // R6
  empty_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> empty);
  // R6
  empty_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> !empty);
  // R6
  full_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(DEPTH)) |=> full);
  // R7
  half_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= CW'(DEPTH / 2)) |=> half_full);
  // R7
  half_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt < CW'(DEPTH / 2)) |=> !half_full);
  // R8
  near_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt <= CW'(AE_LEVEL)) || (cnt >= CW'(AF_LEVEL))) |=> near_edge);
  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)) || (cnt == $past(cnt) - CW'(1))));
endmodule

bind pso_fifo pso_fifo_chk #(
  .DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL), .AF_LEVEL(AF_LEVEL), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .wr_fire(wr_fire), .empty(empty),
  .full(full), .half_full(half_full), .near_edge(near_edge)
);

// File: tb/sim_pso_fifo.sv
module sim_pso_fifo;
  localparam int DW = 16;
  localparam int DEPTH = 1024;
  localparam int AE = 8;
  localparam int AF = DEPTH - 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wstb_n = 1'b1;
  logic shclk = 1'b0;
  logic msb_first = 1'b0;
  logic [DW-1:0] din = '0;
  logic ser_out, empty, full, half_full, near_edge;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] q[$];
  int bpos = 0;
  logic mdir = 1'b0;

  always #4 clk = ~clk;

  pso_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .AE_LEVEL(AE), .AF_LEVEL(AF)) u0 (
    .clk(clk), .rst(rst), .wstb_n(wstb_n), .din(din), .shclk(shclk),
    .msb_first(msb_first), .ser_out(ser_out), .empty(empty), .full(full),
    .half_full(half_full), .near_edge(near_edge)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_near(input int n);
    return (n <= AE) || (n >= AF);
  endfunction

  task automatic check_flags(input string tag);
    int n = q.size();
    chk(empty == (n == 0), tag, "empty", int'(empty), int'(n == 0));
    chk(full == (n == DEPTH), tag, "full", int'(full), int'(n == DEPTH));
    chk(half_full == (n >= DEPTH / 2), tag, "half_full", int'(half_full), int'(n >= DEPTH / 2));
    chk(near_edge == exp_near(n), tag, "near_edge", int'(near_edge), int'(exp_near(n)));
  endtask

  function automatic logic exp_bit();
    return mdir ? q[0][DW-1-bpos] : q[0][bpos];
  endfunction

  task automatic do_write(input logic [DW-1:0] w);
    @(negedge clk);
    din = w;
    wstb_n = 1'b0;
    @(negedge clk);
    wstb_n = 1'b1;
    if (q.size() < DEPTH) q.push_back(w);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_shift(input string tag);
    @(negedge clk);
    if (q.size() > 0) chk(ser_out === exp_bit(), tag, "ser_out", int'(ser_out), int'(exp_bit()));
    else chk(ser_out === 1'b0, "R4 idle", "ser_out", int'(ser_out), 0);
    shclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    shclk = 1'b0;
    @(negedge clk);
    if (q.size() > 0) begin
      bpos++;
      if (bpos == DW) begin
        bpos = 0;
        q.delete(0);
      end
    end
  endtask

  // write rise and last-bit shift rise seen on the same clock sample
  task automatic do_both(input logic [DW-1:0] w, input string tag);
    @(negedge clk);
    din = w;
    wstb_n = 1'b0;
    chk(ser_out === exp_bit(), tag, "ser_out last bit", int'(ser_out), int'(exp_bit()));
    @(negedge clk);
    wstb_n = 1'b1;
    shclk = 1'b1;
    q.push_back(w);
    @(negedge clk);
    @(negedge clk);
    shclk = 1'b0;
    repeat (2) @(negedge clk);
    bpos = 0;
    q.delete(0);
  endtask

  task automatic set_dir(input logic d);
    @(negedge clk);
    msb_first = d;
    mdir = d;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    repeat (4) @(negedge clk);
    chk(empty === 1'b1, "R1", "empty", int'(empty), 1);
    chk(full === 1'b0, "R1", "full", int'(full), 0);
    chk(half_full === 1'b0, "R1", "half_full", int'(half_full), 0);
    chk(near_edge === 1'b0, "R1", "near_edge", int'(near_edge), 0);
    chk(ser_out === 1'b0, "R1", "ser_out", int'(ser_out), 0);
    rst = 1'b0;
    @(negedge clk);
    // R9: count 0 lies inside the near-empty band one edge after reset
    chk(near_edge === 1'b1, "R9", "near_edge after reset", int'(near_edge), 1);
    chk(empty === 1'b1, "R1", "empty after reset", int'(empty), 1);

    // R2 R5 directed words, LSB first then MSB first
    do_write(16'h8001);
    do_write(16'h3C5A);
    check_flags("R2");
    repeat (2 * DW) do_shift("R5 lsb");
    check_flags("R6");
    set_dir(1'b1);
    do_write(16'h8001);
    do_write(16'h1234);
    repeat (2 * DW) do_shift("R5 msb");
    check_flags("R6");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 99));
      if (q.size() == 0 && (r % 7) == 0) set_dir(~mdir);
      if (r < 55) do_write(16'($urandom()));
      else do_shift("R4 random");
      check_flags("R9 random");
    end
    while (q.size() > 0) do_shift("R4 drain");
    check_flags("R6 drained");

    // fill to the top with flag checks at each threshold
    set_dir(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      int n;
      do_write(16'($urandom()));
      n = q.size();
      if (n == AE || n == AE + 1) check_flags("R8 low band");
      if (n == DEPTH / 2 - 1 || n == DEPTH / 2) check_flags("R7 half");
      if (n == AF - 1 || n == AF) check_flags("R8 high band");
    end
    check_flags("R6 full");
    do_write(16'hDEAD);
    chk(q.size() == DEPTH, "R3", "model count", q.size(), DEPTH);
    check_flags("R3 write while full");
    while (q.size() > 0) do_shift("R3 drain after full");
    check_flags("R3 no extra word");

    // R11 shift edges while empty are ignored
    repeat (3) do_shift("R11");
    check_flags("R11");
    do_write(16'hA5C3);
    repeat (DW) do_shift("R11 first word intact");
    check_flags("R11");

    // R10 collisions at count 9 and count 8
    for (int i = 0; i < 9; i++) do_write(16'(16'h0100 + i));
    repeat (DW - 1) do_shift("R10 setup");
    do_both(16'hBEEF, "R10");
    check_flags("R10 count 9");
    chk(near_edge === 1'b0, "R10", "near_edge at 9", int'(near_edge), 0);
    repeat (2 * DW - 1) do_shift("R10 setup");
    do_both(16'hF00D, "R10");
    check_flags("R10 count 8");
    chk(near_edge === 1'b1, "R10", "near_edge at 8", int'(near_edge), 1);
    while (q.size() > 0) do_shift("R10 drain");
    check_flags("R6 final");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule